// File: doc/BRIEF.md
# XOR-Hashed DRAM Address Decoder

This block turns a flat physical byte address into DRAM coordinates: channel, rank, bank group, bank, row, column and byte offset. The placement of every coordinate bit is fixed when the block is elaborated. A single descriptor table lists one entry per coordinate bit. An entry either names one address bit, or names a group of two to four address bits whose parity becomes that coordinate bit. Groups like these let channel and bank selection be spread across higher address bits, so that strided traffic does not pile onto one bank.

The full decode is captured into a register on a cycle where the input is valid, and it is presented one clock later with its own valid flag. The decoded set also carries two extra results. The first is a flat bank number across ranks and bank groups. The second is a flag that marks addresses beyond the mapped space. A separate combinational channel output lets a front-end router steer a request to its channel in the same cycle the address arrives.

Default geometry: 3 byte bits, 10 column bits, 12 row bits, 2 bank bits, 2 bank-group bits, 1 rank bit, 1 pseudo-channel bit and 1 channel bit. That is 32 mapped bits out of a 64-bit address.

Top module: `dram_addr_hash_dec`

## Requirements
- R1: Plain entries copy one address bit into the field. With the default table, byte offset is addr[2:0], column is addr[12:3] and row is addr[31:20], with field bit i taken from table entry i of that field.
- R2: A group entry yields the XOR of all of its listed bits, and the first listed bit is the one it replaces. With the default table, bank[0] = a13^a20^a24, bank[1] = a14^a21, bank group[0] = a15^a22^a25^a28 and bank group[1] = a16.
- R3: Every group reads the unmodified input address, even when one of its bits is the destination of another group. With the default table, channel = a19^a13, using the raw a13 and not the hashed bank[0].
- R4: Pseudo-channel bits extend the rank field above the ordinary rank bits. With the default table, the rank output is {a18, a17}.
- R5: The flat bank output equals (rank × bank groups per rank + bank group) × banks per group + bank, computed on the decoded values.
- R6: The out-of-range flag is 1 exactly when the address exceeds 2^32 − 1, the product of all field sizes minus one. The fields are still decoded from the address in that case.
- R7: When in_valid_i is 1 at a rising edge, out_valid_o is 1 after that edge and every field output shows the decode of the address sampled at that edge.
- R8: When in_valid_i is 0 at a rising edge, out_valid_o is 0 after that edge and every field output keeps its previous value.
- R9: fast_ch_o is combinational. It carries, in the same cycle, the channel that R3 defines for the current addr_i, whether or not in_valid_i is set.
- R10: A synchronous active-high reset clears out_valid_o and every registered field output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Address on addr_i is to be decoded |
| addr_i | input | 64 | Physical byte address |
| fast_ch_o | output | CH_W | Same-cycle channel of addr_i |
| out_valid_o | output | 1 | Registered outputs hold a fresh decode |
| chan_o | output | CH_W | Channel |
| rank_o | output | RANK_W+PC_W | Rank, pseudo-channel bits on top |
| bgrp_o | output | BG_W | Bank group |
| bank_o | output | BANK_W | Bank within group |
| row_o | output | ROW_W | Row |
| col_o | output | COL_W | Column |
| byte_o | output | BYTE_W | Byte offset |
| abs_bank_o | output | RANK_W+PC_W+BG_W+BANK_W | Flat bank number |
| oor_o | output | 1 | Address beyond mapped space |

## Verification
On every cycle, the embedded properties check the valid timing, the holding of the fields on idle cycles, and the agreement of the registered channel with the same-cycle channel one edge earlier. They also check that the flat bank number is consistent with the decoded rank, group and bank, and that any high address bit raises the range flag. The properties cannot show that the parity groups read the right bits, or that one group's result does not feed into another. Only the bench's reference decode shows these, through walking single bits, all-ones patterns and pseudo-random addresses. The pseudo-channel placement is shown the same way.

// File: rtl/dram_hash_pkg.sv
package dram_hash_pkg;

    localparam int ADDR_W  = 64;
    localparam int POS_W   = 6;
    localparam int GRP_MAX = 4;
    localparam int LEN_W   = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [POS_W-1:0]  bitpos_t;

    // One coordinate bit: how many source bits, and which (pos[0] is the destination).
    typedef struct packed {
        logic [LEN_W-1:0]          len;
        bitpos_t [GRP_MAX-1:0]     pos;
    } hash_entry_t;

    // Default geometry
    localparam int DEF_BYTE_W = 3;
    localparam int DEF_COL_W  = 10;
    localparam int DEF_ROW_W  = 12;
    localparam int DEF_BANK_W = 2;
    localparam int DEF_BG_W   = 2;
    localparam int DEF_RANK_W = 1;
    localparam int DEF_PC_W   = 1;
    localparam int DEF_CH_W   = 1;
    localparam int DEF_TOTAL  = DEF_BYTE_W + DEF_COL_W + DEF_ROW_W + DEF_BANK_W
                              + DEF_BG_W + DEF_RANK_W + DEF_PC_W + DEF_CH_W;

    typedef hash_entry_t [DEF_TOTAL-1:0] def_map_t;

    function automatic hash_entry_t mk_ent(input int n, input int p0,
                                           input int p1 = 0, input int p2 = 0,
                                           input int p3 = 0);
        hash_entry_t e;
        e.len    = LEN_W'(n);
        e.pos[0] = POS_W'(p0);
        e.pos[1] = POS_W'(p1);
        e.pos[2] = POS_W'(p2);
        e.pos[3] = POS_W'(p3);
        return e;
    endfunction

    // Entry order: byte, column, row, bank, bank group, rank, pseudo-channel, channel.
    function automatic def_map_t default_map();
        def_map_t m;
        for (int i = 0; i < DEF_BYTE_W + DEF_COL_W; i++) m[i] = mk_ent(1, i);
        for (int i = 0; i < DEF_ROW_W; i++) m[13 + i] = mk_ent(1, 20 + i);
        m[25] = mk_ent(3, 13, 20, 24);
        m[26] = mk_ent(2, 14, 21);
        m[27] = mk_ent(4, 15, 22, 25, 28);
        m[28] = mk_ent(1, 16);
        m[29] = mk_ent(1, 17);
        m[30] = mk_ent(1, 18);
        m[31] = mk_ent(2, 19, 13);
        return m;
    endfunction

    // Parity of the listed bits of the raw address.
    function automatic logic group_parity(input addr_t a, input hash_entry_t e);
        logic p;
        p = 1'b0;
        for (int k = 0; k < GRP_MAX; k++) begin
            if (k < int'(e.len)) p ^= a[e.pos[k]];
        end
        return p;
    endfunction

endpackage

// File: rtl/dah_hash_stage.sv
module dah_hash_stage
    import dram_hash_pkg::*;
#(
    parameter int N = 1,
    parameter hash_entry_t [N-1:0] MAP = '0
) (
    input  addr_t addr_i,
    output addr_t hashed_o
);
    logic [N-1:0] par;

    // Every group sees the raw address, so results never chain.
    for (genvar e = 0; e < N; e++) begin : g_par
        assign par[e] = group_parity(addr_i, MAP[e]);
    end

    always_comb begin
        hashed_o = addr_i;
        for (int e = 0; e < N; e++) begin
            if (MAP[e].len > LEN_W'(1)) hashed_o[MAP[e].pos[0]] = par[e];
        end
    end
endmodule

// File: rtl/dah_field_slice.sv
module dah_field_slice
    import dram_hash_pkg::*;
#(
    parameter int N = 1,
    parameter hash_entry_t [N-1:0] MAP = '0
) (
    input  addr_t        hashed_i,
    output logic [N-1:0] fbits_o
);
    for (genvar e = 0; e < N; e++) begin : g_pick
        assign fbits_o[e] = hashed_i[MAP[e].pos[0]];
    end
endmodule

// File: rtl/dah_range_check.sv
module dah_range_check
    import dram_hash_pkg::*;
#(
    parameter int N = 1
) (
    input  addr_t addr_i,
    output logic  oor_o
);
    localparam addr_t MAX_ADDR = (addr_t'(1) << N) - addr_t'(1);

    assign oor_o = (addr_i > MAX_ADDR);
endmodule

// File: rtl/dram_addr_hash_dec.sv
module dram_addr_hash_dec
    import dram_hash_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int COL_W  = DEF_COL_W,
    parameter int ROW_W  = DEF_ROW_W,
    parameter int BANK_W = DEF_BANK_W,
    parameter int BG_W   = DEF_BG_W,
    parameter int RANK_W = DEF_RANK_W,
    parameter int PC_W   = DEF_PC_W,
    parameter int CH_W   = DEF_CH_W,
    parameter hash_entry_t [BYTE_W+COL_W+ROW_W+BANK_W+BG_W+RANK_W+PC_W+CH_W-1:0] MAP
        = default_map()
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid_i,
    input  logic [63:0]                         addr_i,
    output logic [CH_W-1:0]                     fast_ch_o,
    output logic                                out_valid_o,
    output logic [CH_W-1:0]                     chan_o,
    output logic [RANK_W+PC_W-1:0]              rank_o,
    output logic [BG_W-1:0]                     bgrp_o,
    output logic [BANK_W-1:0]                   bank_o,
    output logic [ROW_W-1:0]                    row_o,
    output logic [COL_W-1:0]                    col_o,
    output logic [BYTE_W-1:0]                   byte_o,
    output logic [RANK_W+PC_W+BG_W+BANK_W-1:0]  abs_bank_o,
    output logic                                oor_o
);
    localparam int N_ENT    = BYTE_W + COL_W + ROW_W + BANK_W + BG_W + RANK_W + PC_W + CH_W;
    localparam int RKT_W    = RANK_W + PC_W;
    localparam int ABS_W    = RKT_W + BG_W + BANK_W;
    localparam int OFF_COL  = BYTE_W;
    localparam int OFF_ROW  = OFF_COL + COL_W;
    localparam int OFF_BANK = OFF_ROW + ROW_W;
    localparam int OFF_BG   = OFF_BANK + BANK_W;
    localparam int OFF_RANK = OFF_BG + BG_W;
    localparam int OFF_CH   = OFF_RANK + RKT_W;
    localparam int BG_N     = 1 << BG_W;
    localparam int BA_N     = 1 << BANK_W;

    // Elaboration-time configuration checks
    if (N_ENT >= ADDR_W) begin : g_bad_total
        $error("mapped bit count must stay below the address width");
    end
    for (genvar e = 0; e < N_ENT; e++) begin : g_chk_len
        if (MAP[e].len < 1 || MAP[e].len > GRP_MAX) begin : g_bad_len
            $error("descriptor group length out of range");
        end
    end
    for (genvar b = 0; b < BYTE_W; b++) begin : g_chk_byte
        if (MAP[b].len != 1 || MAP[b].pos[0] != b) begin : g_bad_byte
            $error("byte offset bits must be plain and contiguous from bit 0");
        end
    end

    addr_t              hashed;
    logic [N_ENT-1:0]   fbits;
    logic               oor_d;
    logic [ABS_W-1:0]   abs_d;

    dah_hash_stage #(.N(N_ENT), .MAP(MAP)) u_hash (
        .addr_i   (addr_i),
        .hashed_o (hashed)
    );

    dah_field_slice #(.N(N_ENT), .MAP(MAP)) u_slice (
        .hashed_i (hashed),
        .fbits_o  (fbits)
    );

    dah_range_check #(.N(N_ENT)) u_range (
        .addr_i (addr_i),
        .oor_o  (oor_d)
    );

    assign fast_ch_o = fbits[OFF_CH +: CH_W];

    assign abs_d = ABS_W'((ABS_W'(fbits[OFF_RANK +: RKT_W]) * ABS_W'(BG_N)
                         + ABS_W'(fbits[OFF_BG +: BG_W])) * ABS_W'(BA_N)
                         + ABS_W'(fbits[OFF_BANK +: BANK_W]));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            chan_o      <= '0;
            rank_o      <= '0;
            bgrp_o      <= '0;
            bank_o      <= '0;
            row_o       <= '0;
            col_o       <= '0;
            byte_o      <= '0;
            abs_bank_o  <= '0;
            oor_o       <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                chan_o     <= fbits[OFF_CH   +: CH_W];
                rank_o     <= fbits[OFF_RANK +: RKT_W];
                bgrp_o     <= fbits[OFF_BG   +: BG_W];
                bank_o     <= fbits[OFF_BANK +: BANK_W];
                row_o      <= fbits[OFF_ROW  +: ROW_W];
                col_o      <= fbits[OFF_COL  +: COL_W];
                byte_o     <= fbits[0        +: BYTE_W];
                abs_bank_o <= abs_d;
                oor_o      <= oor_d;
            end
        end
    end

    // R7: a valid input produces a valid output on the next cycle
    a_r7_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);

    // R8: an idle cycle drops valid and keeps the decoded fields
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> (!out_valid_o && $stable(row_o) && $stable(bank_o)
                         && $stable(chan_o) && $stable(abs_bank_o)));

    // R9: registered channel equals the same-cycle channel seen one edge earlier
    a_r9_fast_match: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> (chan_o == $past(fast_ch_o)));

    // R5: flat bank agrees with the decoded rank, group and bank
    a_r5_abs_bank: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (abs_bank_o == {rank_o, bgrp_o, bank_o}));

    // R6: any address bit above the mapped span raises the flag
    a_r6_high_bit: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && (|(addr_i >> N_ENT))) |=> oor_o);
endmodule

// File: tb/dram_addr_hash_dec_test.sv
module dram_addr_hash_dec_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [63:0] addr_i = '0;
    logic [0:0]  fast_ch_o, chan_o;
    logic        out_valid_o, oor_o;
    logic [1:0]  rank_o, bgrp_o, bank_o;
    logic [11:0] row_o;
    logic [9:0]  col_o;
    logic [2:0]  byte_o;
    logic [5:0]  abs_bank_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dram_addr_hash_dec uut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .addr_i(addr_i),
        .fast_ch_o(fast_ch_o), .out_valid_o(out_valid_o), .chan_o(chan_o),
        .rank_o(rank_o), .bgrp_o(bgrp_o), .bank_o(bank_o), .row_o(row_o),
        .col_o(col_o), .byte_o(byte_o), .abs_bank_o(abs_bank_o), .oor_o(oor_o)
    );

    // Reference state (expected registered outputs)
    logic        e_valid = 0, e_ch = 0, e_oor = 0;
    logic [1:0]  e_rank = 0, e_bg = 0, e_bank = 0;
    logic [11:0] e_row = 0;
    logic [9:0]  e_col = 0;
    logic [2:0]  e_byte = 0;
    int          e_abs = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic ref_ch(input logic [63:0] a);
        return a[19] ^ a[13];
    endfunction

    task automatic compare_all();
        chk(out_valid_o == e_valid, "R7/R8 valid", out_valid_o, e_valid);
        chk(byte_o == e_byte, "R1 byte", byte_o, e_byte);
        chk(col_o == e_col, "R1 column", col_o, e_col);
        chk(row_o == e_row, "R1 row", row_o, e_row);
        chk(bank_o == e_bank, "R2 bank", bank_o, e_bank);
        chk(bgrp_o == e_bg, "R2 bank group", bgrp_o, e_bg);
        chk(chan_o == e_ch, "R3 channel", chan_o, e_ch);
        chk(rank_o == e_rank, "R4 rank", rank_o, e_rank);
        chk(int'(abs_bank_o) == e_abs, "R5 flat bank", abs_bank_o, e_abs);
        chk(oor_o == e_oor, "R6 range flag", oor_o, e_oor);
    endtask

    // One cycle: check what the last edge produced, then drive the next input.
    task automatic step(input logic v, input logic [63:0] a);
        @(negedge clk);
        compare_all();
        in_valid_i = v;
        addr_i = a;
        #1;
        chk(fast_ch_o == ref_ch(a), "R9 fast channel", fast_ch_o, ref_ch(a));
        e_valid = v;
        if (v) begin
            e_byte = a[2:0];
            e_col  = a[12:3];
            e_row  = a[31:20];
            e_bank = {a[14] ^ a[21], a[13] ^ a[20] ^ a[24]};
            e_bg   = {a[16], a[15] ^ a[22] ^ a[25] ^ a[28]};
            e_rank = {a[18], a[17]};
            e_ch   = ref_ch(a);
            e_abs  = (int'(e_rank) * 4 + int'(e_bg)) * 4 + int'(e_bank);
            e_oor  = (a > 64'h0000_0000_FFFF_FFFF);
        end
    endtask

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(negedge clk);
        // R10: drive garbage into the address while reset is held
        addr_i = '1;
        in_valid_i = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid_i = 1'b0;
        // R10: reset state (expected all zero)
        chk(out_valid_o == 0 && row_o == 0 && abs_bank_o == 0 && chan_o == 0,
            "R10 reset state", {out_valid_o, row_o}, 0);

        step(1, 64'h0);
        step(1, 64'h0000_0000_FFFF_FFFF);       // R1 R2 all ones
        step(1, 64'h0000_0000_0000_2000);       // R3 a13 alone: bank0 and channel both 1
        step(1, 64'h0000_0000_0008_2000);       // R3 a13^a19 -> channel 0
        step(1, 64'h0000_0000_0004_0000);       // R4 pseudo-channel bit
        step(1, 64'h0000_0000_0002_0000);       // R4 rank bit
        step(1, 64'h0000_0001_0000_0000);       // R6 just beyond the range
        step(1, 64'h8000_0000_1234_5678);       // R6 top bit, fields still decoded
        for (int b = 0; b < 40; b++) step(1, 64'h1 << b);   // R1 R2 walking ones
        step(0, 64'hFFFF_FFFF_FFFF_FFFF);        // R8 idle: fields must hold
        step(0, 64'h0000_0000_0123_4567);        // R8 second idle cycle
        step(1, 64'h0000_0000_1111_1111);        // back-to-back
        step(1, 64'h0000_0000_2222_2222);
        lfsr = 64'hACE1_2468_1357_BDF0;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            step((i % 7) != 3, (i % 5 == 0) ? lfsr : {32'h0, lfsr[31:0]});
        end
        step(0, 64'h0);
        step(0, 64'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule